// File: doc/BRIEF.md
# Configurable Triple-Core Redundancy Controller

This block sits between three identical processor cores and the rest of the system. It steers the system inputs to the cores and selects, compares or votes the core results, according to one of three redundancy configurations. In independent mode the three cores act as three separate processors. In paired mode cores 0 and 1 run in lockstep on the same input stream and are compared every cycle, while core 2 runs on its own. In triple mode all three cores receive one input stream, and a bitwise two-of-three vote produces the single system result.

In the redundant modes the block looks for a core that has drifted out of step with the others. When it finds one, it raises an out-of-sync flag and issues a one-cycle resynchronization request that names the cores to be realigned. It then waits for the external state-copy mechanism to report completion, and clears the flag only after the participating cores agree again. The configuration is taken from the mode request input while reset is held. It can later be changed by a strobe, or returned to the configuration that was in use before the last change. A change completes only at a point where every core reports that it is quiescent.

Top module: `tcr_ctrl`

## Requirements
- R1: In independent mode (code 2'b00), core_in0/1/2 follow sys_in0/1/2 combinationally. One clock after each cycle, sys_outK equals that cycle's core_outK and sys_vld is 3'b111. lock_err, fault_id and uncorr stay 0 however the cores differ.
- R2: In paired mode (code 2'b01), core_in0 and core_in1 both follow sys_in0, and core_in2 follows sys_in2. One clock later, sys_out0 equals core_out0, sys_out2 equals core_out2, sys_out1 is 0 and sys_vld is 3'b101.
- R3: In paired mode, lock_err is 1 exactly one clock after a cycle in which core_out0 differs from core_out1, and 0 otherwise.
- R4: In triple mode (code 2'b10), all three core inputs follow sys_in0. One clock later, sys_out0 is the bitwise majority of the three core outputs, sys_out1 and sys_out2 are 0, and sys_vld is 3'b001.
- R5: In triple mode, when exactly one core differs from the other two, fault_id is one-hot with bit K marking core K. When all three cores differ pairwise, uncorr is 1 and fault_id is 3'b000. Both flags have one clock of latency.
- R6: When divergence is seen in a redundant mode and no resync is in progress, oos rises and resync_req is high for exactly one clock, in the same clock as the error flags. resync_tgt then names the cores to realign: the one-hot faulty core in triple mode, 3'b011 for the lockstep pair, and 3'b111 when the fault is uncorrectable.
- R7: While waiting for resync_done, further divergence causes no new request. After resync_done, oos clears one clock after a cycle in which the cores agree. If the cores disagree in that cycle instead, a new request is issued.
- R8: While rst_n is low, the active mode is loaded from mode_req. Code 2'b11 is treated as triple mode, and cur_mode reports 2'b10 for it.
- R9: A mode_set strobe starts a switch to mode_req. switching stays 1 until a cycle in which all core_quiet bits are 1. Outputs from switching cycles have sys_vld 3'b000 and no error flags.
- R10: A mode_revert strobe switches back to the mode that was active before the last completed switch. It follows the same quiescence rule as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the mode from mode_req |
| mode_req | input | 2 | Requested mode code |
| mode_set | input | 1 | Strobe: switch to mode_req |
| mode_revert | input | 1 | Strobe: return to the previous mode |
| cur_mode | output | 2 | Active mode (normalized) |
| switching | output | 1 | A mode switch is pending |
| sys_in0 | input | W | System input stream 0 |
| sys_in1 | input | W | System input stream 1 |
| sys_in2 | input | W | System input stream 2 |
| core_in0 | output | W | Input to core 0 |
| core_in1 | output | W | Input to core 1 |
| core_in2 | output | W | Input to core 2 |
| core_out0 | input | W | Result of core 0 |
| core_out1 | input | W | Result of core 1 |
| core_out2 | input | W | Result of core 2 |
| core_quiet | input | 3 | Per-core quiescent / sync-point indication |
| sys_out0 | output | W | System result 0 (registered) |
| sys_out1 | output | W | System result 1 (registered) |
| sys_out2 | output | W | System result 2 (registered) |
| sys_vld | output | 3 | Valid per system result |
| lock_err | output | 1 | Lockstep pair mismatch |
| fault_id | output | 3 | One-hot minority core in triple mode |
| uncorr | output | 1 | No majority core exists |
| oos | output | 1 | Out-of-sync flag |
| resync_req | output | 1 | One-clock resynchronization request |
| resync_tgt | output | 3 | Cores to be realigned |
| resync_done | input | 1 | Resynchronization complete |

## Verification
The hardest situation to reach from the ports is the second round of the resync handshake. Here resync_done has arrived, but the cores disagree again in the very cycle the block uses to confirm agreement. The bench puts the block into triple mode and lets it settle in the idle state with resync_done high and the cores in agreement. It then lowers resync_done, makes core 2 diverge and later corrupts it again while the block waits. After pulsing resync_done, it makes core 1 diverge in the confirming cycle. This shows that no request is issued while the block waits, that a new request naming core 1 is issued, and that oos clears only after a second completion followed by agreement. The data path is swept exhaustively at 4-bit width in triple mode and across all output pairs in paired mode.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

   typedef enum logic [1:0] {
      MODE_PERF = 2'b00,
      MODE_PAIR = 2'b01,
      MODE_TMR  = 2'b10,
      MODE_RSV  = 2'b11
   } mode_e;

   typedef enum logic {
      MS_RUN    = 1'b0,
      MS_SWITCH = 1'b1
   } mode_st_e;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'b00,
      RS_WAIT  = 2'b01,
      RS_CHECK = 2'b10
   } rs_st_e;

   localparam int NCORE = 3;

   function automatic mode_e norm_mode(input logic [1:0] code);
      mode_e m;
      m = mode_e'(code);
      if (m == MODE_RSV) m = MODE_TMR;
      return m;
   endfunction

endpackage

// File: rtl/tcr_vote.sv
module tcr_vote #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] maj,
   output logic         d_ab,
   output logic         d_ac,
   output logic         d_bc
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [1:0] ones;
      always_comb begin
         ones = 2'(a[i]) + 2'(b[i]) + 2'(c[i]);
         maj[i] = (ones >= 2'd2);
      end
   end

   assign d_ab = (a != b);
   assign d_ac = (a != c);
   assign d_bc = (b != c);
endmodule

// File: rtl/tcr_mode_ctl.sv
module tcr_mode_ctl
   import tcr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_req,
   input  logic       mode_set,
   input  logic       mode_revert,
   input  logic [2:0] core_quiet,
   output mode_e      act_mode,
   output logic       busy
);
   mode_st_e st;
   mode_e    prev_mode;
   mode_e    pend_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= MS_RUN;
         act_mode  <= norm_mode(mode_req);
         prev_mode <= norm_mode(mode_req);
         pend_mode <= norm_mode(mode_req);
      end else begin
         case (st)
            MS_RUN: begin
               if (mode_set) begin
                  pend_mode <= norm_mode(mode_req);
                  st        <= MS_SWITCH;
               end else if (mode_revert) begin
                  pend_mode <= prev_mode;
                  st        <= MS_SWITCH;
               end
            end
            default: begin
               if (&core_quiet) begin
                  prev_mode <= act_mode;
                  act_mode  <= pend_mode;
                  st        <= MS_RUN;
               end
            end
         endcase
      end
   end

   assign busy = (st == MS_SWITCH);
endmodule

// File: rtl/tcr_resync.sv
module tcr_resync
   import tcr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       chk_en,
   input  logic       diverge,
   input  logic [2:0] tgt_in,
   input  logic       done,
   output logic       req,
   output logic [2:0] tgt,
   output logic       oos
);
   rs_st_e st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= RS_IDLE;
         req <= 1'b0;
         tgt <= '0;
         oos <= 1'b0;
      end else begin
         req <= 1'b0;
         case (st)
            RS_IDLE: begin
               if (chk_en && diverge) begin
                  req <= 1'b1;
                  tgt <= tgt_in;
                  oos <= 1'b1;
                  st  <= RS_WAIT;
               end
            end
            RS_WAIT: begin
               if (done) st <= RS_CHECK;
            end
            default: begin
               if (chk_en) begin
                  if (diverge) begin
                     req <= 1'b1;
                     tgt <= tgt_in;
                     st  <= RS_WAIT;
                  end else begin
                     oos <= 1'b0;
                     st  <= RS_IDLE;
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/tcr_ctrl.sv
module tcr_ctrl
   import tcr_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   mode_req,
   input  logic         mode_set,
   input  logic         mode_revert,
   output logic [1:0]   cur_mode,
   output logic         switching,
   input  logic [W-1:0] sys_in0,
   input  logic [W-1:0] sys_in1,
   input  logic [W-1:0] sys_in2,
   output logic [W-1:0] core_in0,
   output logic [W-1:0] core_in1,
   output logic [W-1:0] core_in2,
   input  logic [W-1:0] core_out0,
   input  logic [W-1:0] core_out1,
   input  logic [W-1:0] core_out2,
   input  logic [2:0]   core_quiet,
   output logic [W-1:0] sys_out0,
   output logic [W-1:0] sys_out1,
   output logic [W-1:0] sys_out2,
   output logic [2:0]   sys_vld,
   output logic         lock_err,
   output logic [2:0]   fault_id,
   output logic         uncorr,
   output logic         oos,
   output logic         resync_req,
   output logic [2:0]   resync_tgt,
   input  logic         resync_done
);
   if (W < 1 || W > 1024) begin : g_bad_w
      $error("tcr_ctrl: W must be within 1..1024");
   end

   mode_e        mode;
   logic         busy;
   logic [W-1:0] cout [NCORE];
   logic [W-1:0] sout [NCORE];
   logic [W-1:0] maj;
   logic         d01, d02, d12;
   logic         div_c, lock_c, unc_c;
   logic [2:0]   fid_c, tgt_c;

   tcr_mode_ctl u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_req    (mode_req),
      .mode_set    (mode_set),
      .mode_revert (mode_revert),
      .core_quiet  (core_quiet),
      .act_mode    (mode),
      .busy        (busy)
   );

   assign cur_mode  = mode;
   assign switching = busy;

   // input fan-out
   always_comb begin
      unique case (mode)
         MODE_PERF: begin
            core_in0 = sys_in0;
            core_in1 = sys_in1;
            core_in2 = sys_in2;
         end
         MODE_PAIR: begin
            core_in0 = sys_in0;
            core_in1 = sys_in0;
            core_in2 = sys_in2;
         end
         default: begin
            core_in0 = sys_in0;
            core_in1 = sys_in0;
            core_in2 = sys_in0;
         end
      endcase
   end

   assign cout[0] = core_out0;
   assign cout[1] = core_out1;
   assign cout[2] = core_out2;

   tcr_vote #(.W(W)) u_vote (
      .a    (core_out0),
      .b    (core_out1),
      .c    (core_out2),
      .maj  (maj),
      .d_ab (d01),
      .d_ac (d02),
      .d_bc (d12)
   );

   // classification of the current cycle
   always_comb begin
      lock_c = 1'b0;
      unc_c  = 1'b0;
      fid_c  = 3'b000;
      div_c  = 1'b0;
      tgt_c  = 3'b000;
      if (!busy) begin
         unique case (mode)
            MODE_PAIR: begin
               lock_c = d01;
               div_c  = d01;
               tgt_c  = 3'b011;
            end
            MODE_PERF: ;
            default: begin
               unc_c    = d01 & d02 & d12;
               fid_c[0] = d01 & d02 & ~d12;
               fid_c[1] = d01 & d12 & ~d02;
               fid_c[2] = d02 & d12 & ~d01;
               div_c    = d01 | d02 | d12;
               tgt_c    = unc_c ? 3'b111 : fid_c;
            end
         endcase
      end
   end

   // registered output stage, one lane per core
   for (genvar k = 0; k < NCORE; k++) begin : g_lane
      logic [W-1:0] nxt;
      logic         vnx;
      always_comb begin
         nxt = '0;
         vnx = 1'b0;
         if (!busy) begin
            unique case (mode)
               MODE_PERF: begin
                  nxt = cout[k];
                  vnx = 1'b1;
               end
               MODE_PAIR: begin
                  if (k != 1) begin
                     nxt = cout[k];
                     vnx = 1'b1;
                  end
               end
               default: begin
                  if (k == 0) begin
                     nxt = maj;
                     vnx = 1'b1;
                  end
               end
            endcase
         end
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sout[k]    <= '0;
            sys_vld[k] <= 1'b0;
         end else begin
            sout[k]    <= nxt;
            sys_vld[k] <= vnx;
         end
      end
   end

   assign sys_out0 = sout[0];
   assign sys_out1 = sout[1];
   assign sys_out2 = sout[2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_err <= 1'b0;
         fault_id <= 3'b000;
         uncorr   <= 1'b0;
      end else begin
         lock_err <= lock_c;
         fault_id <= fid_c;
         uncorr   <= unc_c;
      end
   end

   tcr_resync u_rs (
      .clk    (clk),
      .rst_n  (rst_n),
      .chk_en (~busy),
      .diverge(div_c),
      .tgt_in (tgt_c),
      .done   (resync_done),
      .req    (resync_req),
      .tgt    (resync_tgt),
      .oos    (oos)
   );
endmodule

// File: rtl/tcr_ctrl_chk.sv
module tcr_ctrl_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         mode_set,
   input logic         mode_revert,
   input logic [1:0]   cur_mode,
   input logic         switching,
   input logic [2:0]   sys_vld,
   input logic         lock_err,
   input logic [2:0]   fault_id,
   input logic         uncorr,
   input logic         oos,
   input logic         resync_req,
   input logic [W-1:0] sys_out1
);
   AST_FAULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fault_id));                                               // R5
   AST_UNCORR_NO_ID: assert property (@(posedge clk) disable iff (!rst_n)
      uncorr |-> (fault_id == 3'b000));                                  // R5
   AST_LOCK_IN_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      lock_err |-> (cur_mode == 2'b01));                                 // R3
   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      resync_req |=> !resync_req);                                       // R6
   AST_OOS_RISE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oos) |-> resync_req);                                        // R6
   AST_SWITCH_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      switching |=> (sys_vld == 3'b000));                                // R9
   AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!switching && !mode_set && !mode_revert) |=> $stable(cur_mode));  // R9
   AST_NO_RSV_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      cur_mode != 2'b11);                                                // R8
   AST_OUT1_PAIR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == 2'b01 && !switching) |=> (sys_out1 == '0));           // R2
endmodule

bind tcr_ctrl tcr_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/tcr_ctrl_test.sv
module tcr_ctrl_test;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode_req = 2'b00;
   logic         mode_set = 1'b0, mode_revert = 1'b0;
   logic [1:0]   cur_mode;
   logic         switching;
   logic [W-1:0] sys_in0 = '0, sys_in1 = '0, sys_in2 = '0;
   logic [W-1:0] core_in0, core_in1, core_in2;
   logic [W-1:0] core_out0 = '0, core_out1 = '0, core_out2 = '0;
   logic [2:0]   core_quiet = 3'b111;
   logic [W-1:0] sys_out0, sys_out1, sys_out2;
   logic [2:0]   sys_vld;
   logic         lock_err;
   logic [2:0]   fault_id;
   logic         uncorr, oos, resync_req;
   logic [2:0]   resync_tgt;
   logic         resync_done = 1'b1;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   tcr_ctrl #(.W(W)) uut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_switch(input logic [1:0] m);
      mode_req = m;
      mode_set = 1'b1;
      step();
      mode_set = 1'b0;
      step();
      step();
   endtask

   function automatic logic [W-1:0] majority(input logic [W-1:0] a, b, c);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) begin
         int s;
         s = int'(a[i]) + int'(b[i]) + int'(c[i]);
         r[i] = (s > 1);
      end
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      // R8: static configuration during reset, reserved code
      mode_req = 2'b11;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      check("R8 reset reserved->triple", 32'(cur_mode), 32'd2);
      rst_n = 1'b0;
      mode_req = 2'b00;
      repeat (3) @(negedge clk);
      check("R8 reset loads independent", 32'(cur_mode), 32'd0);
      check("R6 reset oos", 32'(oos), 32'd0);
      check("R6 reset req", 32'(resync_req), 32'd0);
      check("R1 reset vld", 32'(sys_vld), 32'd0);
      rst_n = 1'b1;
      step();

      // R1: independent sweep
      for (int i = 0; i < 256; i++) begin
         logic [W-1:0] a, b, c;
         a = W'(i); b = W'(i >> 4); c = ~W'(i);
         sys_in0 = b; sys_in1 = c; sys_in2 = a;
         core_out0 = a; core_out1 = b; core_out2 = c;
         #1;
         check("R1 core_in0", 32'(core_in0), 32'(b));
         check("R1 core_in1", 32'(core_in1), 32'(c));
         check("R1 core_in2", 32'(core_in2), 32'(a));
         step();
         check("R1 out0", 32'(sys_out0), 32'(a));
         check("R1 out1", 32'(sys_out1), 32'(b));
         check("R1 out2", 32'(sys_out2), 32'(c));
         check("R1 vld", 32'(sys_vld), 32'h7);
         check("R1 no flags", {lock_err, fault_id, uncorr}, 32'd0);
      end

      // R9: switch to paired waits for quiescence
      core_quiet = 3'b011;
      mode_req = 2'b01;
      mode_set = 1'b1;
      step();
      mode_set = 1'b0;
      check("R9 switching set", 32'(switching), 32'd1);
      check("R9 mode held", 32'(cur_mode), 32'd0);
      step();
      check("R9 vld low while switching", 32'(sys_vld), 32'd0);
      core_quiet = 3'b110;
      step();
      check("R9 still switching", 32'(switching), 32'd1);
      core_quiet = 3'b111;
      step();
      check("R9 switch done", 32'(switching), 32'd0);
      check("R9 new mode paired", 32'(cur_mode), 32'd1);

      // R2, R3: paired sweep
      for (int i = 0; i < 256; i++) begin
         logic [W-1:0] a, b, c;
         a = W'(i); b = W'(i >> 4); c = a ^ 4'h5;
         sys_in0 = c; sys_in1 = a; sys_in2 = b;
         core_out0 = a; core_out1 = b; core_out2 = c;
         #1;
         check("R2 core_in0", 32'(core_in0), 32'(c));
         check("R2 core_in1", 32'(core_in1), 32'(c));
         check("R2 core_in2", 32'(core_in2), 32'(b));
         step();
         check("R2 out0", 32'(sys_out0), 32'(a));
         check("R2 out1", 32'(sys_out1), 32'd0);
         check("R2 out2", 32'(sys_out2), 32'(c));
         check("R2 vld", 32'(sys_vld), 32'h5);
         check("R3 lock_err", 32'(lock_err), 32'(a != b));
      end

      // R8, R10: reserved code then revert
      do_switch(2'b11);
      check("R8 reserved runs as triple", 32'(cur_mode), 32'd2);
      mode_revert = 1'b1;
      step();
      mode_revert = 1'b0;
      step();
      step();
      check("R10 revert to paired", 32'(cur_mode), 32'd1);

      // R9: no flags during a switch, cores disagreeing
      core_out0 = 4'h1; core_out1 = 4'h2; core_out2 = 4'h4;
      core_quiet = 3'b000;
      mode_req = 2'b10;
      mode_set = 1'b1;
      step();
      mode_set = 1'b0;
      step();
      check("R9 no lock_err while switching", 32'(lock_err), 32'd0);
      check("R9 no uncorr while switching", 32'(uncorr), 32'd0);
      core_quiet = 3'b111;
      step();
      check("R9 triple reached", 32'(cur_mode), 32'd2);

      // R4, R5: exhaustive triple sweep
      for (int i = 0; i < 4096; i++) begin
         logic [W-1:0] a, b, c;
         logic [2:0] fid;
         logic unc;
         a = W'(i); b = W'(i >> 4); c = W'(i >> 8);
         sys_in0 = a ^ b; sys_in1 = c; sys_in2 = a;
         core_out0 = a; core_out1 = b; core_out2 = c;
         unc = (a != b) && (a != c) && (b != c);
         fid = 3'b000;
         if (a != b && a != c && b == c) fid = 3'b001;
         if (b != a && b != c && a == c) fid = 3'b010;
         if (c != a && c != b && a == b) fid = 3'b100;
         #1;
         if (i % 64 == 0) begin
            check("R4 core_in1", 32'(core_in1), 32'(a ^ b));
            check("R4 core_in2", 32'(core_in2), 32'(a ^ b));
         end
         step();
         check("R4 voted out", 32'(sys_out0), 32'(majority(a, b, c)));
         check("R4 vld", 32'(sys_vld), 32'h1);
         check("R5 fault_id", 32'(fault_id), 32'(fid));
         check("R5 uncorr", 32'(uncorr), 32'(unc));
      end

      // R6, R7: resync handshake
      core_out0 = 4'h9; core_out1 = 4'h9; core_out2 = 4'h9;
      resync_done = 1'b1;
      repeat (4) step();
      check("R7 settled", 32'(oos), 32'd0);
      resync_done = 1'b0;
      core_out2 = 4'h8;
      step();
      check("R6 req pulse", 32'(resync_req), 32'd1);
      check("R6 oos set", 32'(oos), 32'd1);
      check("R6 target core2", 32'(resync_tgt), 32'h4);
      check("R6 vote masks", 32'(sys_out0), 32'h9);
      core_out2 = 4'hB;
      step();
      check("R6 req one cycle", 32'(resync_req), 32'd0);
      core_out2 = 4'h9;
      step();
      step();
      check("R7 no re-request while waiting", 32'(resync_req), 32'd0);
      check("R7 oos held", 32'(oos), 32'd1);
      resync_done = 1'b1;
      step();
      resync_done = 1'b0;
      check("R7 oos held after done", 32'(oos), 32'd1);
      core_out1 = 4'hD;
      step();
      check("R7 re-request", 32'(resync_req), 32'd1);
      check("R7 re-target core1", 32'(resync_tgt), 32'h2);
      core_out1 = 4'h9;
      step();
      check("R7 oos still set", 32'(oos), 32'd1);
      resync_done = 1'b1;
      step();
      resync_done = 1'b0;
      step();
      check("R7 oos cleared", 32'(oos), 32'd0);

      // R6: uncorrectable target
      core_out0 = 4'h1; core_out1 = 4'h2; core_out2 = 4'h4;
      step();
      check("R6 uncorr target", 32'(resync_tgt), 32'h7);
      check("R5 uncorr flag", 32'(uncorr), 32'd1);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule